// File: doc/BRIEF.md
# Double-Rate Half-Word Memory Bridge

This block lets a 32-bit processor port talk to a memory whose data bus is only 16 bits wide. It does this without ever stalling the processor. The bridge runs from a clock at twice the processor rate, so each processor cycle holds two bridge cycles, called phases. Each word read or word write becomes two half-word memory transactions: the low half goes in the first phase and the high half in the second. Both transactions finish before the next processor rising edge.

The processor side presents a word address, a 32-bit write word, a write enable and a request, all held steady for one processor cycle. The memory side gets a half-word address, which is the word address with the phase appended as its least significant bit. It also gets a half-word of write data and a write strobe. The memory returns its read half-word within the same fast cycle as the address. A read word is assembled from the two halves and registered at the fast edge that ends the second phase. That edge is the next processor rising edge, so the word is valid for the whole following processor cycle.

Top module: `halfword_bridge`

## Requirements
- R1: After reset the first fast cycle is phase 0 (low half). The phase then alternates on every fast clock edge, and each processor cycle is a phase-0 cycle followed by a phase-1 cycle.
- R2: The memory address is the word address shifted left by one, with bit 0 equal to the phase. Word address a maps to half-word 2a in phase 0 and half-word 2a+1 in phase 1, and both phases of one processor cycle carry the same word address.
- R3: For a request with write enable high, the memory write strobe is high in both phases. The write data is cpu_wdata[15:0] in phase 0 and cpu_wdata[31:16] in phase 1, so the memory holds the full word after the cycle.
- R4: For a request with write enable low, cpu_rdata becomes {half-word 2a+1, half-word 2a} at the fast edge that ends phase 1. It keeps that value through the whole next processor cycle.
- R5: cpu_rdata keeps its last value in any processor cycle that is idle or a write.
- R6: The memory write strobe stays low in idle cycles and read cycles, so exactly two half-word writes happen per word write.
- R7: While reset is asserted the phase is 0, cpu_rdata is zero and no memory write occurs.
- R8: The second access of a processor cycle repeats the command captured at the end of phase 0. Processor inputs that change during phase 1 (the early setup of the next cycle) do not alter that access, so back-to-back operations on the same word complete in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Bridge clock at twice the processor rate; every other rising edge is a processor rising edge |
| rst | input | 1 | Synchronous active-high reset, released so that the next cycle is phase 0 |
| cpu_req | input | 1 | Processor access request for the current processor cycle |
| cpu_we | input | 1 | 1 = word write, 0 = word read (qualified by cpu_req) |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write word |
| cpu_rdata | output | DATA_W | Assembled read word, registered |
| mem_addr | output | ADDR_W+1 | Memory half-word address, bit 0 = phase |
| mem_wdata | output | MEM_W | Memory write half-word |
| mem_we | output | 1 | Memory write strobe, one half-word per fast cycle |
| mem_rdata | input | MEM_W | Memory read half-word, valid in the same fast cycle as mem_addr |

## Verification
One clock edge does two jobs. The edge that ends a read's phase 1 loads the assembled word into cpu_rdata. The same edge opens phase 0 of the next operation, and the processor inputs for that operation were already changed during phase 1. The bench provokes this with back-to-back sequences on the same word: write, read, write new data, read. A scoreboard then expects each read to return the value in force at its own cycle, and expects cpu_rdata to hold across the write and idle cycles in between. The memory model's half-word array and the count of strobes seen in each phase judge whether a write leaked into, or missed, the wrong phase.

// File: rtl/brg_pkg.sv
package brg_pkg;
   // half-word lane selected in each fast cycle
   typedef enum logic {
      PH_LO = 1'b0,
      PH_HI = 1'b1
   } phase_e;

   function automatic phase_e next_phase(input phase_e p);
      return (p == PH_LO) ? PH_HI : PH_LO;
   endfunction
endpackage

// File: rtl/brg_phase.sv
module brg_phase
   import brg_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   output phase_e phase_o
);
   phase_e phase_q;

   always_ff @(posedge clk) begin
      if (rst) phase_q <= PH_LO;
      else     phase_q <= next_phase(phase_q);
   end

   assign phase_o = phase_q;
endmodule

// File: rtl/brg_cmd_hold.sv
module brg_cmd_hold
   import brg_pkg::*;
#(
   parameter int AW = 16,
   parameter int HW = 16
)(
   input  logic          clk,
   input  logic          rst,
   input  phase_e        phase_i,
   input  logic          req_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [HW-1:0] whi_i,
   output logic          wr_o,
   output logic          rd_o,
   output logic [AW-1:0] addr_o,
   output logic [HW-1:0] whi_o
);
   logic          wr_q, rd_q;
   logic [AW-1:0] addr_q;
   logic [HW-1:0] whi_q;

   // command is frozen at the edge that closes phase 0
   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q   <= 1'b0;
         rd_q   <= 1'b0;
         addr_q <= '0;
         whi_q  <= '0;
      end else if (phase_i == PH_LO) begin
         wr_q   <= req_i & we_i;
         rd_q   <= req_i & ~we_i;
         addr_q <= addr_i;
         whi_q  <= whi_i;
      end
   end

   always_comb begin
      if (phase_i == PH_LO) begin
         wr_o   = req_i & we_i & ~rst;
         rd_o   = req_i & ~we_i & ~rst;
         addr_o = addr_i;
         whi_o  = whi_i;
      end else begin
         wr_o   = wr_q;
         rd_o   = rd_q;
         addr_o = addr_q;
         whi_o  = whi_q;
      end
   end
endmodule

// File: rtl/brg_lane_sel.sv
module brg_lane_sel #(
   parameter int HW    = 16,
   parameter int LANES = 2,
   localparam int SW   = (LANES > 1) ? $clog2(LANES) : 1
)(
   input  logic [LANES*HW-1:0] word_i,
   input  logic [SW-1:0]       sel_i,
   output logic [HW-1:0]       lane_o
);
   logic [HW-1:0] lanes [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = word_i[g*HW +: HW];
   end

   assign lane_o = lanes[sel_i];
endmodule

// File: rtl/brg_rd_pack.sv
module brg_rd_pack
   import brg_pkg::*;
#(
   parameter int HW = 16,
   localparam int DW = 2 * HW
)(
   input  logic          clk,
   input  logic          rst,
   input  phase_e        phase_i,
   input  logic          rd_i,
   input  logic [HW-1:0] half_i,
   output logic [DW-1:0] word_o
);
   logic [HW-1:0] lo_q;
   logic [DW-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q   <= '0;
         word_q <= '0;
      end else if (rd_i) begin
         if (phase_i == PH_LO) lo_q   <= half_i;
         else                  word_q <= {half_i, lo_q};
      end
   end

   assign word_o = word_q;
endmodule

// File: rtl/halfword_bridge.sv
module halfword_bridge
   import brg_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int MEM_W  = 16
)(
   input  logic              clk_2x,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [ADDR_W:0]   mem_addr,
   output logic [MEM_W-1:0]  mem_wdata,
   output logic              mem_we,
   input  logic [MEM_W-1:0]  mem_rdata
);
   if (DATA_W != 2 * MEM_W) begin : g_bad_width
      $error("halfword_bridge: DATA_W must be twice MEM_W");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("halfword_bridge: ADDR_W must be at least 1");
   end

   phase_e              phase_q;
   logic                wr_eff, rd_eff;
   logic [ADDR_W-1:0]   addr_eff;
   logic [MEM_W-1:0]    whi_eff;

   brg_phase u_phase (
      .clk     (clk_2x),
      .rst     (rst),
      .phase_o (phase_q)
   );

   brg_cmd_hold #(.AW(ADDR_W), .HW(MEM_W)) u_hold (
      .clk     (clk_2x),
      .rst     (rst),
      .phase_i (phase_q),
      .req_i   (cpu_req),
      .we_i    (cpu_we),
      .addr_i  (cpu_addr),
      .whi_i   (cpu_wdata[DATA_W-1:MEM_W]),
      .wr_o    (wr_eff),
      .rd_o    (rd_eff),
      .addr_o  (addr_eff),
      .whi_o   (whi_eff)
   );

   brg_lane_sel #(.HW(MEM_W), .LANES(2)) u_lane (
      .word_i  ({whi_eff, cpu_wdata[MEM_W-1:0]}),
      .sel_i   (phase_q),
      .lane_o  (mem_wdata)
   );

   brg_rd_pack #(.HW(MEM_W)) u_pack (
      .clk     (clk_2x),
      .rst     (rst),
      .phase_i (phase_q),
      .rd_i    (rd_eff),
      .half_i  (mem_rdata),
      .word_o  (cpu_rdata)
   );

   assign mem_addr = {addr_eff, phase_q};
   assign mem_we   = wr_eff;
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
   parameter int AW = 16,
   parameter int DW = 32
)(
   input logic          clk,
   input logic          rst,
   input logic          ph,
   input logic          rd_now,
   input logic          cpu_req,
   input logic          cpu_we,
   input logic [AW:0]   mem_addr,
   input logic          mem_we,
   input logic [DW-1:0] cpu_rdata
);
   // R1
   phase_alt_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (ph != $past(ph)));

   // R2
   addr_pair_chk: assert property (@(posedge clk) disable iff (rst)
      !ph |=> (mem_addr[AW:1] == $past(mem_addr[AW:1])) && mem_addr[0]);

   // R3
   wr_pair_chk: assert property (@(posedge clk) disable iff (rst)
      (!ph && mem_we) |=> mem_we);

   // R3
   wr_origin_chk: assert property (@(posedge clk) disable iff (rst)
      (ph && mem_we) |-> $past(mem_we));

   // R6
   idle_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (!ph && !(cpu_req && cpu_we)) |-> !mem_we);

   // R5
   rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(ph && rd_now) |=> $stable(cpu_rdata));

   // R7
   reset_state_chk: assert property (@(posedge clk)
      $past(rst) |-> (cpu_rdata == '0) && !ph);
endmodule

bind halfword_bridge brg_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
   .clk       (clk_2x),
   .rst       (rst),
   .ph        (phase_q),
   .rd_now    (rd_eff),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .cpu_rdata (cpu_rdata)
);

// File: tb/test_halfword_bridge.sv
module test_halfword_bridge;
   localparam int AW = 8;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [31:0]   cpu_wdata = '0;
   logic [31:0]   cpu_rdata;
   logic [AW:0]   mem_addr;
   logic [15:0]   mem_wdata;
   logic          mem_we;
   logic [15:0]   mem_rdata;

   always #5 clk = ~clk;

   halfword_bridge #(.ADDR_W(AW), .DATA_W(32), .MEM_W(16)) i_halfword_bridge (
      .clk_2x(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_rdata(mem_rdata)
   );

   // half-word memory model, read within the cycle
   logic [15:0] mem [2*NW];
   logic [31:0] refw [NW];
   assign mem_rdata = mem[mem_addr];

   function automatic logic [15:0] init_hw(input int i);
      return 16'(i * 16'h0123) ^ 16'h5A5A;
   endfunction

   initial begin
      for (int i = 0; i < 2*NW; i++) mem[i] = init_hw(i);
      for (int a = 0; a < NW; a++) refw[a] = {init_hw(2*a+1), init_hw(2*a)};
   end

   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

   // bench copy of the phase and processor-cycle count
   logic bph = 1'b0;
   int   pcyc = 0;
   int   we_lo = 0, we_hi = 0;
   always @(posedge clk) begin
      if (rst) begin
         bph  <= 1'b0;
         pcyc <= 0;
      end else begin
         bph <= ~bph;
         if (bph) pcyc <= pcyc + 1;
         if (mem_we && !bph) we_lo <= we_lo + 1;
         if (mem_we && bph)  we_hi <= we_hi + 1;
      end
   end

   int errors = 0, checks = 0, nwr = 0;
   logic [31:0] last_exp = '0;

   typedef struct {
      int          due;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sbq[$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: sets up the next processor cycle during phase 1
   task automatic op(input bit rq, input bit we, input logic [AW-1:0] a,
                     input logic [31:0] d, input string tag);
      sb_item_t it;
      @(negedge clk);
      while (bph != 1'b1) @(negedge clk);
      cpu_req = rq; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      if (rq && !we) last_exp = refw[a];
      if (rq && we) begin
         refw[a] = d;
         nwr++;
      end
      it.due = pcyc + 2;
      it.exp = last_exp;
      it.tag = tag;
      sbq.push_back(it);
   endtask

   // monitor: compares cpu_rdata in phase 0 of the cycle after each op
   always @(negedge clk) begin
      if (!rst && !bph) begin
         while (sbq.size() > 0 && sbq[0].due <= pcyc) begin
            check(sbq[0].tag, cpu_rdata, sbq[0].exp);
            void'(sbq.pop_front());
         end
      end
   end

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R7: reset state
      check("R7 rdata", cpu_rdata, 32'h0);
      check("R7 mem_we", {31'h0, mem_we}, 32'h0);
      rst = 1'b0;

      // R4 reads at both address ends and the middle
      op(1, 0, 8'd0,   '0, "R4 read a0");
      op(1, 0, 8'd255, '0, "R4 read a255");
      op(1, 0, 8'd77,  '0, "R4 read a77");
      // R5 hold across idle
      op(0, 0, 8'd3,   '0, "R5 idle hold");
      op(0, 1, 8'd3,   32'hDEAD_BEEF, "R6 we without req");
      // R3/R8 write then immediate readback
      op(1, 1, 8'd5,   32'h1234_5678, "R5 hold over write");
      op(1, 0, 8'd5,   '0, "R3 R8 readback a5");
      op(1, 1, 8'd5,   32'hCAFE_F00D, "R8 rewrite hold");
      op(1, 0, 8'd5,   '0, "R8 second readback a5");
      op(1, 1, 8'd255, 32'hA5A5_0001, "R5 hold write a255");
      op(1, 0, 8'd255, '0, "R3 readback a255");
      // back-to-back writes to neighbours, then reads
      op(1, 1, 8'd6,   32'h0BAD_C0DE, "R5 hold write a6");
      op(1, 1, 8'd7,   32'h7777_8888, "R5 hold write a7");
      op(1, 0, 8'd6,   '0, "R2 read a6");
      op(1, 0, 8'd7,   '0, "R2 read a7");
      op(0, 0, 8'd0,   '0, "R5 idle end");
      op(0, 0, 8'd0,   '0, "R5 idle end2");
      op(0, 0, 8'd0,   '0, "R5 idle end3");
      repeat (8) @(negedge clk);

      // R2/R3: half-word placement in memory
      check("R2 R3 mem[10]", {16'h0, mem[10]}, 32'h0000_F00D);
      check("R2 R3 mem[11]", {16'h0, mem[11]}, 32'h0000_CAFE);
      check("R2 R3 mem[511]", {16'h0, mem[511]}, 32'h0000_A5A5);
      check("R2 mem[6] untouched", {16'h0, mem[6]}, {16'h0, init_hw(6)});
      // R1/R3/R6: two strobes per write, one in each phase
      check("R1 R3 phase0 strobes", we_lo, nwr);
      check("R1 R6 phase1 strobes", we_hi, nwr);
      check("R8 queue drained", sbq.size(), 0);
      finish_run();
   end
endmodule